// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small fully associative cache of page translations. A requester presents a virtual address, the identifier of the current address space and an access kind (load, store or instruction fetch). One cycle later the block answers with a hit, a miss or a permission fault. On a hit it also returns the physical address and the updated dirty and reference bits of the matching entry, so that they can be written back to the page table. Pages are 4 KB. The low 12 address bits are the page offset and are copied into the physical address unchanged. The cached frame number supplies the bits above them.

Every entry is tagged with an address-space identifier, so translations from several processes can be held at the same time. A context switch therefore needs no flush. On a miss, an external page-table walker installs the translation through the fill port, and the requester retries the access. Software can invalidate all entries at once, or only the entries that belong to one address space.

Top module: `tlb_asid`

## Requirements
- R1: On a hit, `rsp_pa_o` equals the entry's frame number in bits PA_W-1:12 and the request's virtual address bits 11:0 in bits 11:0.
- R2: `rsp_valid_o` is high in the cycle after a cycle with `req_valid_i` high, and low otherwise. While it is high, exactly one of `rsp_hit_o`, `rsp_miss_o` and `rsp_fault_o` is high. While it is low, all three are low.
- R3: A lookup matches only a valid entry whose stored page number equals virtual address bits VA_W-1:12 and whose stored identifier equals `req_asid_i`. An entry with the same page number but a different identifier gives a miss.
- R4: Permission bits are bit 0 read, bit 1 write and bit 2 execute. Access codes are 0 load, 1 store and 2 fetch; code 3 always faults. A matching lookup whose access bit is clear gives `rsp_fault_o`, sets `rsp_pa_o` to zero, reports the entry's stored dirty and reference bits, and leaves those bits unchanged.
- R5: A permitted hit sets the entry's reference bit. A permitted store hit also sets its dirty bit. `rsp_ref_o` and `rsp_dirty_o` report the values after this update.
- R6: A miss gives `rsp_miss_o`, with `rsp_pa_o`, `rsp_dirty_o` and `rsp_ref_o` all zero. Once a fill has installed the translation, the same retried access hits.
- R7: A fill chooses its slot in this order: the entry that already holds the same page number and identifier; otherwise the lowest-index invalid entry; otherwise the entry at the round-robin pointer. The pointer starts at 0 and advances by one, modulo the entry count, only when it is used. A fill clears the reference bit and loads the dirty bit from `fill_dirty_i`.
- R8: `flush_all_i` invalidates every entry in a single cycle, so that a lookup issued in the next cycle misses.
- R9: `flush_asid_i` invalidates only the entries whose identifier equals `flush_asid_val_i`. Other entries keep hitting.
- R10: A fill that arrives in the same cycle as either flush is ignored. A lookup sees the table as it was before the fill, flush or bit update of its own cycle.
- R11: After reset every entry is invalid, the round-robin pointer is 0 and `rsp_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request |
| req_va_i | input | VA_W | Virtual address |
| req_asid_i | input | ASID_W | Address-space identifier of the request |
| req_acc_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| rsp_valid_o | output | 1 | Response present |
| rsp_hit_o | output | 1 | Translation found and permitted |
| rsp_miss_o | output | 1 | No matching entry |
| rsp_fault_o | output | 1 | Matching entry forbids this access |
| rsp_pa_o | output | PA_W | Physical address (zero unless hit) |
| rsp_dirty_o | output | 1 | Dirty bit of the matching entry |
| rsp_ref_o | output | 1 | Reference bit of the matching entry |
| fill_valid_i | input | 1 | Install a translation |
| fill_vpn_i | input | VA_W-12 | Page number to install |
| fill_asid_i | input | ASID_W | Identifier to install |
| fill_pfn_i | input | PA_W-12 | Frame number to install |
| fill_perm_i | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| fill_dirty_i | input | 1 | Initial dirty bit |
| flush_all_i | input | 1 | Invalidate all entries |
| flush_asid_i | input | 1 | Invalidate the entries of one identifier |
| flush_asid_val_i | input | ASID_W | Identifier to invalidate |

## Verification
The bound checker checks the properties that hold on every cycle. These are the response timing and the rule that exactly one outcome is reported, the offset passthrough on hits, the zero address on faults, the reference and dirty bits reported after permitted hits, and a miss following a full flush. The rest depends on the history of the table, and only the bench scenarios can show it. This covers victim selection, including duplicate refills and the round-robin wrap; flushes that spare other identifiers; fills dropped during a flush; and lookups in the same cycle as a fill. The bench follows it with a table model that it derives from the requirements.

// File: rtl/tlb_asid_pkg.sv
package tlb_asid_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam int unsigned PERM_R = 0;
  localparam int unsigned PERM_W = 1;
  localparam int unsigned PERM_X = 2;
  localparam int unsigned OFFS_W = 12;

  function automatic logic perm_ok(input logic [2:0] perm, input acc_e acc);
    unique case (acc)
      ACC_LOAD:  perm_ok = perm[PERM_R];
      ACC_STORE: perm_ok = perm[PERM_W];
      ACC_FETCH: perm_ok = perm[PERM_X];
      default:   perm_ok = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int unsigned N      = 64,
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned ASID_W = 8
) (
  input  logic [N-1:0]             valid_i,
  input  logic [N-1:0][VPN_W-1:0]  tab_vpn_i,
  input  logic [N-1:0][ASID_W-1:0] tab_asid_i,
  input  logic [VPN_W-1:0]         key_vpn_i,
  input  logic [ASID_W-1:0]        key_asid_i,
  output logic [N-1:0]             match_o
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match_o[i] = valid_i[i] && (tab_vpn_i[i] == key_vpn_i) && (tab_asid_i[i] == key_asid_i);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned N = 64,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     valid_i,
  input  logic [N-1:0]     dup_i,
  input  logic             fill_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] rr_q, dup_idx, free_idx;
  logic             has_dup, has_free;

  always_comb begin
    dup_idx  = '0;
    free_idx = '0;
    has_free = 1'b0;
    has_dup  = |dup_i;
    for (int i = 0; i < N; i++) begin
      if (dup_i[i]) dup_idx = dup_idx | IDX_W'(i);
    end
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_idx = IDX_W'(i);
        has_free = 1'b1;
      end
    end
    if (has_dup)       idx_o = dup_idx;
    else if (has_free) idx_o = free_idx;
    else               idx_o = rr_q;
  end

  // pointer moves only when it actually picked the victim
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
    end else if (fill_i && !has_dup && !has_free) begin
      rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_resp.sv
module tlb_resp
  import tlb_asid_pkg::*;
#(
  parameter int unsigned N     = 64,
  parameter int unsigned PA_W  = 32,
  localparam int unsigned PFN_W = PA_W - OFFS_W,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  input  logic [1:0]               req_acc_i,
  input  logic [OFFS_W-1:0]        req_offs_i,
  input  logic [N-1:0]             match_i,
  input  logic [N-1:0][2:0]        tab_perm_i,
  input  logic [N-1:0][PFN_W-1:0]  tab_pfn_i,
  input  logic [N-1:0]             tab_dirty_i,
  input  logic [N-1:0]             tab_ref_i,
  output logic [N-1:0]             upd_o,
  output logic                     upd_store_o,
  output logic                     rsp_valid_o,
  output logic                     rsp_hit_o,
  output logic                     rsp_miss_o,
  output logic                     rsp_fault_o,
  output logic [PA_W-1:0]          rsp_pa_o,
  output logic                     rsp_dirty_o,
  output logic                     rsp_ref_o
);
  logic [IDX_W-1:0] idx;
  logic             any, allowed, is_store;
  acc_e             acc;

  always_comb begin
    acc = acc_e'(req_acc_i);
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (match_i[i]) idx = idx | IDX_W'(i);
    end
    any         = |match_i;
    allowed     = any && perm_ok(tab_perm_i[idx], acc);
    is_store    = (acc == ACC_STORE);
    upd_o       = (req_valid_i && allowed) ? match_i : '0;
    upd_store_o = is_store;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_miss_o  <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_pa_o    <= '0;
      rsp_dirty_o <= 1'b0;
      rsp_ref_o   <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_hit_o   <= req_valid_i && allowed;
      rsp_miss_o  <= req_valid_i && !any;
      rsp_fault_o <= req_valid_i && any && !allowed;
      rsp_pa_o    <= (req_valid_i && allowed) ? {tab_pfn_i[idx], req_offs_i} : '0;
      rsp_dirty_o <= req_valid_i && any && (tab_dirty_i[idx] || (allowed && is_store));
      rsp_ref_o   <= req_valid_i && any && (tab_ref_i[idx] || allowed);
    end
  end
endmodule

// File: rtl/tlb_asid.sv
module tlb_asid
  import tlb_asid_pkg::*;
#(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned VA_W    = 32,
  parameter int unsigned PA_W    = 32,
  parameter int unsigned ASID_W  = 8,
  localparam int unsigned VPN_W  = VA_W - OFFS_W,
  localparam int unsigned PFN_W  = PA_W - OFFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [VA_W-1:0]   req_va_i,
  input  logic [ASID_W-1:0] req_asid_i,
  input  logic [1:0]        req_acc_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_miss_o,
  output logic              rsp_fault_o,
  output logic [PA_W-1:0]   rsp_pa_o,
  output logic              rsp_dirty_o,
  output logic              rsp_ref_o,
  input  logic              fill_valid_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [PFN_W-1:0]  fill_pfn_i,
  input  logic [2:0]        fill_perm_i,
  input  logic              fill_dirty_i,
  input  logic              flush_all_i,
  input  logic              flush_asid_i,
  input  logic [ASID_W-1:0] flush_asid_val_i
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0]             valid_q, dirty_q, ref_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
  logic [ENTRIES-1:0][PFN_W-1:0]  pfn_q;
  logic [ENTRIES-1:0][2:0]        perm_q;

  logic [ENTRIES-1:0] hit_vec, dup_vec, upd_vec;
  logic [IDX_W-1:0]   victim;
  logic               upd_store, fill_go;

  assign fill_go = fill_valid_i && !flush_all_i && !flush_asid_i;

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lookup (
    .valid_i   (valid_q),
    .tab_vpn_i (vpn_q),
    .tab_asid_i(asid_q),
    .key_vpn_i (req_va_i[VA_W-1:OFFS_W]),
    .key_asid_i(req_asid_i),
    .match_o   (hit_vec)
  );

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_dup (
    .valid_i   (valid_q),
    .tab_vpn_i (vpn_q),
    .tab_asid_i(asid_q),
    .key_vpn_i (fill_vpn_i),
    .key_asid_i(fill_asid_i),
    .match_o   (dup_vec)
  );

  tlb_victim #(.N(ENTRIES)) u_victim (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_q),
    .dup_i  (dup_vec),
    .fill_i (fill_go),
    .idx_o  (victim)
  );

  tlb_resp #(.N(ENTRIES), .PA_W(PA_W)) u_resp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_acc_i  (req_acc_i),
    .req_offs_i (req_va_i[OFFS_W-1:0]),
    .match_i    (hit_vec),
    .tab_perm_i (perm_q),
    .tab_pfn_i  (pfn_q),
    .tab_dirty_i(dirty_q),
    .tab_ref_i  (ref_q),
    .upd_o      (upd_vec),
    .upd_store_o(upd_store),
    .rsp_valid_o(rsp_valid_o),
    .rsp_hit_o  (rsp_hit_o),
    .rsp_miss_o (rsp_miss_o),
    .rsp_fault_o(rsp_fault_o),
    .rsp_pa_o   (rsp_pa_o),
    .rsp_dirty_o(rsp_dirty_o),
    .rsp_ref_o  (rsp_ref_o)
  );

  // per entry: flush > fill > hit bit update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
      ref_q   <= '0;
      vpn_q   <= '0;
      asid_q  <= '0;
      pfn_q   <= '0;
      perm_q  <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (flush_all_i || (flush_asid_i && asid_q[i] == flush_asid_val_i)) begin
          valid_q[i] <= 1'b0;
        end else if (fill_go && victim == IDX_W'(i)) begin
          valid_q[i] <= 1'b1;
          vpn_q[i]   <= fill_vpn_i;
          asid_q[i]  <= fill_asid_i;
          pfn_q[i]   <= fill_pfn_i;
          perm_q[i]  <= fill_perm_i;
          dirty_q[i] <= fill_dirty_i;
          ref_q[i]   <= 1'b0;
        end else if (upd_vec[i]) begin
          ref_q[i] <= 1'b1;
          if (upd_store) dirty_q[i] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tlb_asid_chk.sv
module tlb_asid_chk #(
  parameter int unsigned VA_W = 32,
  parameter int unsigned PA_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic [VA_W-1:0] req_va_i,
  input logic [1:0]      req_acc_i,
  input logic            flush_all_i,
  input logic            rsp_valid_o,
  input logic            rsp_hit_o,
  input logic            rsp_miss_o,
  input logic            rsp_fault_o,
  input logic [PA_W-1:0] rsp_pa_o,
  input logic            rsp_dirty_o,
  input logic            rsp_ref_o
);
  a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  a_r2_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  a_r2_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $onehot({rsp_hit_o, rsp_miss_o, rsp_fault_o}));
  a_r2_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !(rsp_hit_o || rsp_miss_o || rsp_fault_o));
  a_r1_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> rsp_pa_o[11:0] == $past(req_va_i[11:0]));
  a_r4_fault_pa_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> rsp_pa_o == '0);
  a_r5_ref_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> rsp_ref_o);
  a_r5_store_dirty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_hit_o && $past(req_acc_i) == 2'd1) |-> rsp_dirty_o);
  a_r6_miss_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_miss_o |-> (rsp_pa_o == '0 && !rsp_dirty_o && !rsp_ref_o));
  a_r8_flush_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_i ##1 req_valid_i |=> rsp_miss_o);
endmodule

bind tlb_asid tlb_asid_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_va_i   (req_va_i),
  .req_acc_i  (req_acc_i),
  .flush_all_i(flush_all_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_hit_o  (rsp_hit_o),
  .rsp_miss_o (rsp_miss_o),
  .rsp_fault_o(rsp_fault_o),
  .rsp_pa_o   (rsp_pa_o),
  .rsp_dirty_o(rsp_dirty_o),
  .rsp_ref_o  (rsp_ref_o)
);

// File: tb/tlb_asid_bench.sv
module tlb_asid_bench;
  localparam int N       = 4;
  localparam int VA_W    = 24;
  localparam int PA_W    = 24;
  localparam int ASID_W  = 3;
  localparam int VPN_W   = VA_W - 12;
  localparam int PFN_W   = PA_W - 12;
  localparam int CLK_PER = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [VA_W-1:0]   req_va = '0;
  logic [ASID_W-1:0] req_asid = '0;
  logic [1:0]        req_acc = '0;
  logic              rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_dirty, rsp_ref;
  logic [PA_W-1:0]   rsp_pa;
  logic              fill_valid = 1'b0;
  logic [VPN_W-1:0]  fill_vpn = '0;
  logic [ASID_W-1:0] fill_asid = '0;
  logic [PFN_W-1:0]  fill_pfn = '0;
  logic [2:0]        fill_perm = '0;
  logic              fill_dirty = 1'b0;
  logic              flush_all = 1'b0;
  logic              flush_asid = 1'b0;
  logic [ASID_W-1:0] flush_asid_val = '0;

  always #(CLK_PER / 2) clk = ~clk;

  tlb_asid #(.ENTRIES(N), .VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W)) u_tlb_asid (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_va_i(req_va), .req_asid_i(req_asid), .req_acc_i(req_acc),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_miss_o(rsp_miss), .rsp_fault_o(rsp_fault),
    .rsp_pa_o(rsp_pa), .rsp_dirty_o(rsp_dirty), .rsp_ref_o(rsp_ref),
    .fill_valid_i(fill_valid), .fill_vpn_i(fill_vpn), .fill_asid_i(fill_asid),
    .fill_pfn_i(fill_pfn), .fill_perm_i(fill_perm), .fill_dirty_i(fill_dirty),
    .flush_all_i(flush_all), .flush_asid_i(flush_asid), .flush_asid_val_i(flush_asid_val)
  );

  // table model built from the requirements
  logic              m_valid [N];
  logic [VPN_W-1:0]  m_vpn   [N];
  logic [ASID_W-1:0] m_asid  [N];
  logic [PFN_W-1:0]  m_pfn   [N];
  logic [2:0]        m_perm  [N];
  logic              m_dirty [N];
  logic              m_ref   [N];
  int                m_rr;

  int    checks = 0;
  int    fails  = 0;
  logic  pend = 1'b0;
  logic [PA_W+5:0] exp_vec;
  string exp_tag;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic acc_ok(input logic [2:0] p, input logic [1:0] a);
    case (a)
      2'd0:    return p[0];
      2'd1:    return p[1];
      2'd2:    return p[2];
      default: return 1'b0;
    endcase
  endfunction

  // one clock: check previous response, drive new inputs, predict, update model
  task automatic step(input string tag,
                      input logic rv, input logic [VA_W-1:0] va, input logic [ASID_W-1:0] asid,
                      input logic [1:0] acc,
                      input logic fv, input logic [VPN_W-1:0] fvpn, input logic [ASID_W-1:0] fasid,
                      input logic [PFN_W-1:0] fpfn, input logic [2:0] fperm, input logic fdirty,
                      input logic fa, input logic fs, input logic [ASID_W-1:0] fsa);
    int  m, v, free;
    logic ok;
    @(negedge clk);
    if (pend)
      check(exp_tag, 64'({rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_dirty, rsp_ref, rsp_pa}),
            64'(exp_vec));
    req_valid = rv; req_va = va; req_asid = asid; req_acc = acc;
    fill_valid = fv; fill_vpn = fvpn; fill_asid = fasid; fill_pfn = fpfn;
    fill_perm = fperm; fill_dirty = fdirty;
    flush_all = fa; flush_asid = fs; flush_asid_val = fsa;
    m = -1;
    for (int i = 0; i < N; i++)
      if (m_valid[i] && m_vpn[i] == va[VA_W-1:12] && m_asid[i] == asid) m = i;
    exp_tag = tag;
    pend = 1'b1;
    if (!rv) exp_vec = '0;
    else if (m < 0) exp_vec = {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, {PA_W{1'b0}}};
    else begin
      ok = acc_ok(m_perm[m], acc);
      if (ok)
        exp_vec = {1'b1, 1'b1, 1'b0, 1'b0, m_dirty[m] | (acc == 2'd1), 1'b1, m_pfn[m], va[11:0]};
      else
        exp_vec = {1'b1, 1'b0, 1'b0, 1'b1, m_dirty[m], m_ref[m], {PA_W{1'b0}}};
    end
    // victim from pre-cycle state
    v = -1; free = -1;
    for (int i = 0; i < N; i++)
      if (m_valid[i] && m_vpn[i] == fvpn && m_asid[i] == fasid) v = i;
    for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) free = i;
    if (rv && m >= 0 && acc_ok(m_perm[m], acc)) begin
      m_ref[m] = 1'b1;
      if (acc == 2'd1) m_dirty[m] = 1'b1;
    end
    if (fa) begin
      for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
    end else if (fs) begin
      for (int i = 0; i < N; i++) if (m_asid[i] == fsa) m_valid[i] = 1'b0;
    end else if (fv) begin
      if (v < 0) begin
        if (free >= 0) v = free;
        else begin
          v = m_rr;
          m_rr = (m_rr + 1) % N;
        end
      end
      m_valid[v] = 1'b1; m_vpn[v] = fvpn; m_asid[v] = fasid; m_pfn[v] = fpfn;
      m_perm[v] = fperm; m_dirty[v] = fdirty; m_ref[v] = 1'b0;
    end
  endtask

  task automatic look(input string tag, input logic [VPN_W-1:0] vpn, input logic [11:0] offs,
                      input logic [ASID_W-1:0] asid, input logic [1:0] acc);
    step(tag, 1'b1, {vpn, offs}, asid, acc, 1'b0, '0, '0, '0, '0, 1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic fill(input string tag, input logic [VPN_W-1:0] vpn, input logic [ASID_W-1:0] asid,
                      input logic [PFN_W-1:0] pfn, input logic [2:0] perm, input logic d);
    step(tag, 1'b0, '0, '0, '0, 1'b1, vpn, asid, pfn, perm, d, 1'b0, 1'b0, '0);
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, '0, '0, '0, 1'b0, '0, '0, '0, '0, 1'b0, 1'b0, 1'b0, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [11:0] offs [3];
    offs[0] = 12'h000; offs[1] = 12'hABC; offs[2] = 12'hFFF;
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0; m_vpn[i] = '0; m_asid[i] = '0; m_pfn[i] = '0;
      m_perm[i] = '0; m_dirty[i] = 0; m_ref[i] = 0;
    end
    m_rr = 0;
    repeat (3) @(negedge clk);
    check("R11 rsp_valid in reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    idle("R11 idle after reset");
    look("R11 empty table misses", 12'h001, 12'h123, 3'd1, 2'd0);

    // R6: miss, fill, retry hits
    look("R6 miss before fill", 12'h001, 12'h010, 3'd1, 2'd0);
    fill("R6 fill", 12'h001, 3'd1, 12'hA01, 3'b001, 1'b0);
    look("R6 retry hits", 12'h001, 12'h010, 3'd1, 2'd0);
    fill("R7 fill free slot", 12'h002, 3'd1, 12'hA02, 3'b011, 1'b0);
    fill("R7 fill free slot", 12'h003, 3'd2, 12'hA03, 3'b101, 1'b0);
    fill("R3 same vpn other asid", 12'h001, 3'd2, 12'hA04, 3'b111, 1'b1);

    // R1 R3 R4 R5: sweep vpn x asid x access x offset
    for (int v = 0; v < 5; v++)
      for (int a = 1; a < 3; a++)
        for (int c = 0; c < 4; c++)
          for (int o = 0; o < 3; o++)
            look("R1 R3 R4 R5 sweep", 12'(v), offs[o], 3'(a), 2'(c));

    // R7: duplicate refill overwrites in place, then round-robin with wrap
    fill("R7 duplicate refill", 12'h002, 3'd1, 12'hB02, 3'b010, 1'b0);
    look("R7 refilled pfn", 12'h002, 12'h444, 3'd1, 2'd1);
    look("R7 refilled perm faults load", 12'h002, 12'h444, 3'd1, 2'd0);
    for (int p = 0; p < 8; p++) begin
      fill("R7 round robin fill", 12'h040 + 12'(p), 3'd3, 12'h800 + 12'(p), 3'(p), p[0]);
      for (int c = 0; c < 3; c++)
        look("R4 R7 perm sweep", 12'h040 + 12'(p), 12'(p * 17), 3'd3, 2'(c));
      look("R7 evicted older entry", 12'h040 + 12'((p + 4) % 8), 12'h0, 3'd3, 2'd0);
    end

    // R9: per-identifier flush
    step("R9 flush asid", 1'b0, '0, '0, '0, 1'b0, '0, '0, '0, '0, 1'b0, 1'b0, 1'b1, 3'd3);
    fill("R9 fill other asid", 12'h0F0, 3'd5, 12'hC00, 3'b111, 1'b0);
    fill("R9 fill flushed asid", 12'h0F1, 3'd3, 12'hC01, 3'b111, 1'b0);
    step("R9 flush asid 3", 1'b0, '0, '0, '0, 1'b0, '0, '0, '0, '0, 1'b0, 1'b0, 1'b1, 3'd3);
    look("R9 flushed asid misses", 12'h0F1, 12'h0, 3'd3, 2'd0);
    look("R9 other asid still hits", 12'h0F0, 12'h5A5, 3'd5, 2'd2);

    // R10: lookup same cycle as fill sees old table; fill during flush dropped
    step("R10 lookup with fill", 1'b1, {12'h077, 12'h321}, 3'd6, 2'd0,
         1'b1, 12'h077, 3'd6, 12'hD77, 3'b001, 1'b0, 1'b0, 1'b0, '0);
    look("R10 retry after fill", 12'h077, 12'h321, 3'd6, 2'd0);
    step("R10 fill during flush", 1'b0, '0, '0, '0,
         1'b1, 12'h078, 3'd6, 12'hD78, 3'b001, 1'b0, 1'b0, 1'b1, 3'd0);
    look("R10 dropped fill misses", 12'h078, 12'h0, 3'd6, 2'd0);
    step("R10 hit during flush", 1'b1, {12'h0F0, 12'h001}, 3'd5, 2'd1,
         1'b0, '0, '0, '0, '0, 1'b0, 1'b1, 1'b0, '0);

    // R8: flush all
    fill("R8 refill", 12'h0F0, 3'd5, 12'hC10, 3'b111, 1'b1);
    step("R8 flush all", 1'b0, '0, '0, '0, 1'b1, 12'h0F3, 3'd5, 12'hC11, 3'b111, 1'b0,
         1'b1, 1'b0, '0);
    look("R8 after flush all", 12'h0F0, 12'h0, 3'd5, 2'd0);
    look("R8 dropped fill", 12'h0F3, 12'h0, 3'd5, 2'd0);
    fill("R5 dirty preset fill", 12'h100, 3'd7, 12'hEEE, 3'b111, 1'b1);
    look("R5 preset dirty reported", 12'h100, 12'h9, 3'd7, 2'd0);
    idle("R2 no request no response");
    idle("R2 drain");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule